// File: doc/BRIEF.md
# Pipelined Late-Write Synchronous Memory

This block is a single-port synchronous memory that is 36 bits wide. Address, command and byte enables are registered on the rising clock edge. The data for a write is supplied two clock edges after its command. Read data comes out of an output register one edge after the array access. Because of this skew, a write's data cycle lands exactly where a read's data cycle would have been. The bus can therefore turn around between reads and writes with no idle cycle.

The block holds two pending-write stages. The first holds a write whose data has not yet arrived. The second holds a write whose data was captured and is committed to the array on the following edge. A read that matches either stage receives the newer bytes. Its result is therefore always the value left by every write commanded before it.

A short burst mode lets one loaded address generate three further addresses inside an aligned four-word block. The order within the block is either linear or interleaved. The read output and the write-data input are separate ports. The read output is high-impedance whenever it carries no read data, so the two can share one external bus.

Top module: `dlw_sram`

## Requirements
- R1: A cycle starts at a rising edge where `load_n` is low. If `sel_n` is also low, `wr_n` low makes the cycle a write and `wr_n` high makes it a read. If `sel_n` is high at that edge, the cycle is a deselect with no array access and no bus output.
- R2: For a read captured at edge N, `rd_oe` is high and `rd_bus` holds the addressed word from just after edge N+1 until edge N+2.
- R3: The data for a write captured at edge N is taken from `wr_data` at edge N+2.
- R4: `be_n[i]` is active low and controls lane i, which is bits [9i+8:9i]. It is sampled with the command, not with the data. Lanes whose bit is high keep their stored contents. With `be_n` = 4'b0000 the whole word is written.
- R5: Reads and writes may alternate on consecutive edges in any order without idle cycles. During a write's data cycle `rd_oe` is low and `rd_bus` is high-impedance.
- R6: A read whose address matches an earlier write that is still pending returns the merged bytes of that write. This holds whether the write's data arrives at the read's output edge or was captured one edge earlier and is not yet committed.
- R7: An edge with `load_n` high, following an active (selected) load, continues the burst. It keeps the loaded cycle type and ignores `wr_n` and `sel_n`. `be_n` is sampled for each burst beat.
- R8: Burst beat k (k = 1..3) keeps address bits above bit 1. It sets the two low bits to (start + k) mod 4 when `burst_ilv` is 0, and to start XOR k when `burst_ilv` is 1. The sequence wraps after the fourth beat.
- R9: While `rst_n` is low at an edge, `rd_oe` goes low, `rd_bus` is high-impedance and every pending write is dropped without reaching the array.
- R10: An edge with `load_n` high that follows a deselect or a reset performs no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load_n | input | 1 | Low: load a new address and command; high: advance the burst |
| sel_n | input | 1 | Active-low select, sampled only when loading |
| wr_n | input | 1 | Cycle type at load: low write, high read |
| addr | input | ADDR_W | Word address |
| be_n | input | 4 | Active-low lane enables, one per 9-bit lane |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved (held static) |
| wr_data | input | 36 | Write data, due two edges after the write command |
| rd_bus | output | 36 | Read data; high-impedance when not driven |
| rd_oe | output | 1 | High while `rd_bus` carries read data |

## Verification
The hardest case is a read that overtakes a write to the same address whose bytes exist only on the data input or in the uncommitted holding stage. Stimulus reaches the first case by issuing a write followed immediately by a read of the same word. It reaches the second case by placing one unrelated command between them. Partial lane enables are used in both so that a merge error shows up as wrong lanes. Burst beats are additionally driven with a write command on the type input and garbage on the data input. A later read of the same block then exposes any beat that changed type.

// File: rtl/dlw_pkg.sv
package dlw_pkg;
  localparam int LANES   = 4;
  localparam int LANE_W  = 9;
  localparam int DATA_W  = LANES * LANE_W;
  localparam int BURST_W = 2;

  // Replace the lanes whose active-low enable is low.
  function automatic logic [DATA_W-1:0] lane_merge(input logic [DATA_W-1:0] old_w,
                                                   input logic [DATA_W-1:0] new_w,
                                                   input logic [LANES-1:0]  en_n);
    logic [DATA_W-1:0] r;
    r = old_w;
    for (int i = 0; i < LANES; i++)
      if (!en_n[i]) r[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
    return r;
  endfunction

  // Low address bits of burst beat k for a given start.
  function automatic logic [BURST_W-1:0] burst_lo(input logic [BURST_W-1:0] start,
                                                  input logic [BURST_W-1:0] k,
                                                  input logic               ilv);
    return ilv ? (start ^ k) : (start + k);
  endfunction
endpackage

// File: rtl/dlw_cmd.sv
module dlw_cmd
  import dlw_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_n,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  be_n,
  input  logic              burst_ilv,
  output logic              cur_vld,
  output logic              cur_wr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LANES-1:0]  cur_be_n
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic               b_act, b_wr;
  logic [ADDR_W-1:0]  b_base;
  logic [BURST_W-1:0] b_k;
  logic [BURST_W-1:0] k_next;
  logic               load_evt, adv_evt;

  assign load_evt = !load_n;
  assign adv_evt  = load_n && b_act;
  assign k_next   = b_k + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_act    <= 1'b0;
      b_wr     <= 1'b0;
      b_base   <= '0;
      b_k      <= '0;
      cur_vld  <= 1'b0;
      cur_wr   <= 1'b0;
      cur_addr <= '0;
      cur_be_n <= '1;
    end else if (load_evt) begin
      b_act    <= !sel_n;
      b_wr     <= !wr_n;
      b_base   <= addr;
      b_k      <= '0;
      cur_vld  <= !sel_n;
      cur_wr   <= !wr_n;
      cur_addr <= addr;
      cur_be_n <= be_n;
    end else begin
      cur_vld  <= adv_evt;
      cur_wr   <= b_wr;
      cur_be_n <= be_n;
      cur_addr <= {b_base[ADDR_W-1:BURST_W], burst_lo(b_base[BURST_W-1:0], k_next, burst_ilv)};
      if (adv_evt) b_k <= k_next;
    end
  end

  // R7: a burst beat keeps the cycle type of its loaded command
  p_burst_type_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && cur_vld) |=> (cur_vld && cur_wr == $past(cur_wr)));

  // R8: burst addresses stay inside the aligned four-word block
  p_burst_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && cur_vld) |=> (cur_addr[ADDR_W-1:BURST_W] == $past(cur_addr[ADDR_W-1:BURST_W])));

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = '0;
endmodule

// File: rtl/dlw_wpipe.sv
module dlw_wpipe
  import dlw_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cur_vld,
  input  logic              cur_wr,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [LANES-1:0]  cur_be_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pend_vld,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [LANES-1:0]  pend_be_n,
  output logic              wb_vld,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [LANES-1:0]  wb_be_n,
  output logic [DATA_W-1:0] wb_data
);
  logic wr_cmd;
  assign wr_cmd = cur_vld && cur_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_addr <= '0;
      pend_be_n <= '1;
      wb_vld    <= 1'b0;
      wb_addr   <= '0;
      wb_be_n   <= '1;
      wb_data   <= '0;
    end else begin
      pend_vld  <= wr_cmd;
      pend_addr <= cur_addr;
      pend_be_n <= cur_be_n;
      wb_vld    <= pend_vld;
      wb_addr   <= pend_addr;
      wb_be_n   <= pend_be_n;
      if (pend_vld) wb_data <= wr_data;
    end
  end

  // R3: a write command reaches the commit stage with its own address
  p_commit_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd |=> ##1 (wb_vld && wb_addr == $past(cur_addr, 2)));
endmodule

// File: rtl/dlw_array.sv
module dlw_array
  import dlw_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [LANES-1:0]  wbe_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] cur_word, nxt_word;

  assign cur_word = mem[waddr];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign nxt_word[g*LANE_W +: LANE_W] = wbe_n[g] ? cur_word[g*LANE_W +: LANE_W]
                                                   : wdata[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk)
    if (we) mem[waddr] <= nxt_word;

  assign rdata = mem[raddr];
endmodule

// File: rtl/dlw_rdpath.sv
module dlw_rdpath
  import dlw_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_vld,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] arr_q,
  input  logic              pend_vld,
  input  logic [ADDR_W-1:0] pend_addr,
  input  logic [LANES-1:0]  pend_be_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wb_vld,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic [LANES-1:0]  wb_be_n,
  input  logic [DATA_W-1:0] wb_data,
  output logic [DATA_W-1:0] q,
  output logic              q_oe
);
  logic              hit_wb, hit_pend;
  logic [DATA_W-1:0] after_wb, byp;

  assign hit_wb   = wb_vld && (wb_addr == rd_addr);
  assign hit_pend = pend_vld && (pend_addr == rd_addr);
  // Older holding stage first, then the write whose data is on the input now.
  assign after_wb = hit_wb ? lane_merge(arr_q, wb_data, wb_be_n) : arr_q;
  assign byp      = hit_pend ? lane_merge(after_wb, wr_data, pend_be_n) : after_wb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q    <= '0;
      q_oe <= 1'b0;
    end else begin
      q_oe <= rd_vld;
      if (rd_vld) q <= byp;
    end
  end

  // R6: with full lane enables, a pending hit returns the input word
  p_fwd_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld && hit_pend && pend_be_n == '0) |=> (q_oe && q == $past(wr_data)));
endmodule

// File: rtl/dlw_sram.sv
module dlw_sram
  import dlw_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_n,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  be_n,
  input  logic              burst_ilv,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_bus,
  output logic              rd_oe
);
  logic              cur_vld, cur_wr;
  logic [ADDR_W-1:0] cur_addr;
  logic [LANES-1:0]  cur_be_n;
  logic              pend_vld, wb_vld;
  logic [ADDR_W-1:0] pend_addr, wb_addr;
  logic [LANES-1:0]  pend_be_n, wb_be_n;
  logic [DATA_W-1:0] wb_data, arr_q, q;
  logic              rd_vld;

  assign rd_vld = cur_vld && !cur_wr;

  dlw_cmd #(.ADDR_W(ADDR_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .sel_n(sel_n), .wr_n(wr_n),
    .addr(addr), .be_n(be_n), .burst_ilv(burst_ilv),
    .cur_vld(cur_vld), .cur_wr(cur_wr), .cur_addr(cur_addr), .cur_be_n(cur_be_n));

  dlw_wpipe #(.ADDR_W(ADDR_W)) u_wpipe (
    .clk(clk), .rst_n(rst_n), .cur_vld(cur_vld), .cur_wr(cur_wr),
    .cur_addr(cur_addr), .cur_be_n(cur_be_n), .wr_data(wr_data),
    .pend_vld(pend_vld), .pend_addr(pend_addr), .pend_be_n(pend_be_n),
    .wb_vld(wb_vld), .wb_addr(wb_addr), .wb_be_n(wb_be_n), .wb_data(wb_data));

  dlw_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .we(wb_vld), .waddr(wb_addr), .wbe_n(wb_be_n), .wdata(wb_data),
    .raddr(cur_addr), .rdata(arr_q));

  dlw_rdpath #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_vld(rd_vld), .rd_addr(cur_addr), .arr_q(arr_q),
    .pend_vld(pend_vld), .pend_addr(pend_addr), .pend_be_n(pend_be_n),
    .wr_data(wr_data), .wb_vld(wb_vld), .wb_addr(wb_addr), .wb_be_n(wb_be_n),
    .wb_data(wb_data), .q(q), .q_oe(rd_oe));

  assign rd_bus = rd_oe ? q : 'z;

  // R2: a selected read load drives the bus after the following edge
  p_read_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && !sel_n && wr_n) |=> ##1 rd_oe);

  // R5: the cycle carrying write data leaves the bus undriven
  p_write_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && !sel_n && !wr_n) |=> ##1 !rd_oe);

  // R1: a deselect load produces no bus output
  p_desel_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && sel_n) |=> ##1 !rd_oe);
endmodule

// File: tb/tb_dlw_sram.sv
module tb_dlw_sram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 36;
  localparam logic [DW-1:0] JUNK = 36'hF0F0F0F0F;

  logic clk = 1'b0, rst_n = 1'b0;
  logic load_n = 1'b1, sel_n = 1'b1, wr_n = 1'b1, burst_ilv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [3:0] be_n = 4'hF;
  logic [DW-1:0] wr_data = JUNK;
  wire  [DW-1:0] rd_bus;
  wire  rd_oe;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench reference state
  logic [DW-1:0] mdl [1 << AW];
  logic m_act = 0, m_wr = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0] m_k = '0;
  logic w1_v = 0, w2_v = 0, p_v = 0;
  logic [AW-1:0] w1_a, w2_a, p_a;
  logic [3:0] w1_be, w2_be;
  logic [DW-1:0] w1_d, w2_d;
  string p_tag = "";

  always #(CLK_PERIOD/2) clk = ~clk;

  dlw_sram #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .sel_n(sel_n), .wr_n(wr_n),
    .addr(addr), .be_n(be_n), .burst_ilv(burst_ilv), .wr_data(wr_data),
    .rd_bus(rd_bus), .rd_oe(rd_oe));

  function automatic logic [DW-1:0] bmerge(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                           input logic [3:0] en_n);
    logic [DW-1:0] r;
    r = o;
    for (int l = 0; l < 4; l++)
      if (en_n[l] == 1'b0)
        for (int b = 0; b < 9; b++) r[l*9 + b] = n[l*9 + b];
    return r;
  endfunction

  function automatic logic [1:0] border(input logic [1:0] s, input logic [1:0] k, input logic il);
    logic [1:0] r;
    if (il) r = s ^ k;
    else    r = (s + k) % 4;
    return r;
  endfunction

  function automatic logic [DW-1:0] pat(input int i);
    return 36'h5A5A00000 ^ (36'h10203 * i) ^ (36'(i) << 30);
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One clock: drive inputs, model the edge, check after it.
  task automatic cyc(input logic ld_n, input logic s_n, input logic w_n,
                     input logic [AW-1:0] a, input logic [3:0] be,
                     input logic [DW-1:0] d, input string tag);
    logic ev, ew;
    logic [AW-1:0] ea;
    logic eoe;
    logic [DW-1:0] ed;
    string etag;
    if (!ld_n) begin
      m_act = !s_n; m_wr = !w_n; m_base = a; m_k = 0;
      ev = !s_n; ew = !w_n; ea = a;
    end else begin
      ev = m_act; ew = m_wr;
      if (m_act) m_k = m_k + 1;
      ea = {m_base[AW-1:2], border(m_base[1:0], m_k, burst_ilv)};
    end
    load_n = ld_n; sel_n = s_n; wr_n = w_n; addr = a; be_n = be;
    wr_data = w2_v ? w2_d : JUNK;
    @(posedge clk);
    if (w2_v) mdl[w2_a] = bmerge(mdl[w2_a], w2_d, w2_be);
    eoe = p_v; ed = mdl[p_a]; etag = p_tag;
    w2_v = w1_v; w2_a = w1_a; w2_be = w1_be; w2_d = w1_d;
    w1_v = ev && ew; w1_a = ea; w1_be = be; w1_d = d;
    p_v = ev && !ew; p_a = ea; p_tag = tag;
    @(negedge clk);
    check(eoe ? etag : "R5", {35'd0, rd_oe}, {35'd0, eoe});
    if (eoe) check(etag, rd_bus, ed);
    else     check("R5", rd_bus, {DW{1'bz}});
  endtask

  task automatic nop();
    cyc(1'b0, 1'b1, 1'b1, '0, 4'hF, '0, "R1");
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    cyc(1'b0, 1'b0, 1'b1, a, 4'hF, '0, tag);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [3:0] be, input logic [DW-1:0] d);
    cyc(1'b0, 1'b0, 1'b0, a, be, d, "R3");
  endtask

  task automatic flush();
    nop(); nop(); nop();
  endtask

  task automatic do_reset();
    rst_n = 0; load_n = 1; sel_n = 1;
    w1_v = 0; w2_v = 0; p_v = 0; m_act = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R9", {35'd0, rd_oe}, 36'd0);
    check("R9", rd_bus, {DW{1'bz}});
    rst_n = 1;
  endtask

  // R9: reset state
  task automatic t_reset();
    do_reset();
  endtask

  // R1 R2 R3: fill every word, then read back
  task automatic t_fill_read();
    for (int i = 0; i < (1 << AW); i++) wr(AW'(i), 4'h0, pat(i));
    flush();
    for (int i = 0; i < (1 << AW); i += 7) rd(AW'(i), "R2");
    rd(AW'(1), "R1"); rd(AW'(63), "R1");
    flush();
  endtask

  // R4: lane enables
  task automatic t_bytes();
    wr(AW'(5), 4'b1010, 36'h123456789);
    wr(AW'(6), 4'b1111, 36'h0);
    wr(AW'(7), 4'b0111, 36'hFEDCBA987);
    nop(); nop();
    rd(AW'(5), "R4"); rd(AW'(6), "R4"); rd(AW'(7), "R4");
    flush();
  endtask

  // R5 R6: back-to-back turnaround and bypass
  task automatic t_turn();
    wr(AW'(10), 4'b0000, 36'hAAAA0001);
    rd(AW'(10), "R6");               // hits write whose data arrives at the output edge
    wr(AW'(11), 4'b1001, 36'h777777777);
    rd(AW'(10), "R5");
    rd(AW'(11), "R6");               // data captured one edge earlier, not committed
    wr(AW'(12), 4'b0110, 36'h3C3C3C3C3);
    wr(AW'(12), 4'b1100, 36'h155555555);
    rd(AW'(12), "R6");               // two pending writes to the same word
    rd(AW'(12), "R6");
    wr(AW'(13), 4'b0000, 36'h0BEEF);
    rd(AW'(14), "R5");
    wr(AW'(14), 4'b0000, 36'h0CAFE);
    rd(AW'(13), "R5");
    rd(AW'(14), "R6");
    flush();
  endtask

  // R7 R8: bursts in both orders
  task automatic t_burst();
    burst_ilv = 0;
    rd(AW'(6), "R8");                                  // 6,7,4,5
    cyc(1'b1, 1'b1, 1'b0, '0, 4'h0, 36'h111, "R7");    // wr_n, sel_n ignored
    cyc(1'b1, 1'b0, 1'b0, '0, 4'h0, 36'h222, "R7");
    cyc(1'b1, 1'b0, 1'b1, '0, 4'hF, '0, "R8");
    flush();
    rd(AW'(4), "R7"); rd(AW'(5), "R7"); rd(AW'(7), "R7");
    flush();
    burst_ilv = 1;
    cyc(1'b0, 1'b0, 1'b0, AW'(9), 4'b0000, 36'h900000001, "R8"); // 9,8,11,10
    cyc(1'b1, 1'b1, 1'b1, '0, 4'b1110, 36'h800000002, "R7");
    cyc(1'b1, 1'b0, 1'b1, '0, 4'b0000, 36'hB00000003, "R7");
    cyc(1'b1, 1'b0, 1'b1, '0, 4'b0101, 36'hA00000004, "R7");
    cyc(1'b1, 1'b0, 1'b1, '0, 4'b0000, 36'hC00000005, "R8"); // wraps to 9
    rd(AW'(11), "R8");                                 // 11,10,9,8
    cyc(1'b1, 1'b0, 1'b0, '0, 4'hF, '0, "R8");
    cyc(1'b1, 1'b0, 1'b0, '0, 4'hF, '0, "R8");
    cyc(1'b1, 1'b0, 1'b0, '0, 4'hF, '0, "R8");
    flush();
    burst_ilv = 0;
  endtask

  // R10 R1: deselect, then advances, must not access
  task automatic t_desel();
    cyc(1'b0, 1'b1, 1'b0, AW'(20), 4'h0, 36'h0, "R1");
    cyc(1'b1, 1'b0, 1'b0, '0, 4'h0, 36'h0, "R10");
    cyc(1'b1, 1'b0, 1'b1, '0, 4'h0, 36'h0, "R10");
    cyc(1'b1, 1'b0, 1'b0, '0, 4'h0, 36'h0, "R10");
    flush();
    rd(AW'(20), "R10"); rd(AW'(21), "R10"); rd(AW'(22), "R10"); rd(AW'(23), "R10");
    flush();
  endtask

  // R9: reset drops a pending write; later advances do nothing
  task automatic t_reset_pending();
    wr(AW'(30), 4'b0000, 36'h0DEAD);
    wr_data = JUNK;
    do_reset();
    cyc(1'b1, 1'b0, 1'b0, '0, 4'h0, 36'h0, "R10");
    flush();
    rd(AW'(30), "R9"); rd(AW'(31), "R9");
    flush();
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mdl[i] = '0;
    @(negedge clk);
    t_reset();
    t_fill_read();
    t_bytes();
    t_turn();
    t_burst();
    t_desel();
    t_reset_pending();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule